// File: doc/BRIEF.md
# Pipelined One-Hot Rule Encoder

This block sits behind a bank of pattern comparators. Each cycle it receives one match bit per rule and reports whether any rule fired and, if so, which rule fired as a binary number. It is a plain encoder for a one-hot input, not a priority encoder. The result is valid only while at most one bit is set. When two or more bits are set in the same cycle, the block raises a separate error flag so that downstream logic can discard the index.

The encoder is a tree of registered reduction levels. Each node folds up to four child nodes. Each output bit of a node is either an OR of at most four inputs or a two-or-more count of at most four inputs. Every level adds one register stage. The latency is therefore the number of times the rule count must be divided by four, rounding up, to reach one. With 47 rules that is three cycles.

A new vector can enter on every clock. Each result comes out tagged with its own output valid bit.

Top module: `onehot_rule_encoder`

## Requirements
- R1: A valid input vector with exactly one bit set at position p gives hit_o = 1 and idx_o = p. Bit 0 of match_i is rule 0.
- R2: A valid all-zero input gives hit_o = 0, idx_o = 0 and err_o = 0 while out_valid_o = 1.
- R3: A valid input with two or more bits set gives err_o = 1 and hit_o = 1. idx_o is unspecified in that result. This holds both when the set bits fall inside one group of four rules and when they fall in different groups.
- R4: A valid input with zero or one bit set gives err_o = 0.
- R5: out_valid_o equals valid_i delayed by exactly LEVELS clock cycles. LEVELS is the count of divide-by-four rounding-up steps that take NUM_RULES to 1, which is 3 for 47 rules. Each result appears in that same cycle.
- R6: While valid_i = 0, match_i is ignored. In the corresponding output cycle, out_valid_o, hit_o, err_o and idx_o are all 0.
- R7: While rst_n is low, all outputs are 0.
- R8: Vectors presented on consecutive cycles produce results on consecutive cycles, in the same order, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | match_i carries a vector this cycle |
| match_i | input | NUM_RULES | One match bit per rule, bit p is rule p |
| out_valid_o | output | 1 | A result is present this cycle |
| hit_o | output | 1 | Some rule matched |
| err_o | output | 1 | Two or more rules matched in the same input vector |
| idx_o | output | IDX_W | Binary number of the matching rule, 0 when no rule matched |

## Verification
The bound checker keeps a shadow of the input valid and the input bit count, aligned by its own shift register. On every cycle it checks the output timing, the error flag against the count of set bits, the hit flag for single-bit vectors, and the all-quiet outputs on idle cycles. Only the scoreboard checks the exact rule number for each position. It also shows that clashes are caught both inside one group of four and across groups, and that back-to-back vectors stay separate.

// File: rtl/enc_pkg.sv
package enc_pkg;

    // Node count after k divide-by-four reduction rounds.
    function automatic int enc_nodes(input int rules, input int k);
        int n;
        n = rules;
        for (int i = 0; i < k; i++) begin
            n = (n + 3) / 4;
        end
        return n;
    endfunction

    // Rounds needed to fold the rule vector down to one node.
    function automatic int enc_levels(input int rules);
        int n;
        int l;
        n = rules;
        l = 0;
        for (int i = 0; i < 32; i++) begin
            if (n > 1) begin
                n = (n + 3) / 4;
                l = l + 1;
            end
        end
        return l;
    endfunction

    // Offset of level k's output nodes in the flattened node store.
    function automatic int enc_base(input int rules, input int k);
        int s;
        s = 0;
        for (int j = 1; j <= k; j++) begin
            s = s + enc_nodes(rules, j);
        end
        return s;
    endfunction

endpackage

// File: rtl/enc_valid_pipe.sv
module enc_valid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [DEPTH-1:0] taps;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d.taps = DEPTH'({pipe_q.taps, d_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q.taps[DEPTH-1];
endmodule

// File: rtl/enc_level.sv
// One registered reduction level: every output node folds up to four
// children. Lane 0 of each node is the "any match" lane; the other lanes
// are the index bit ORs. The error bit is the OR of the children's error
// bits plus a two-or-more count on the children's lane 0.
module enc_level #(
    parameter int IN_N  = 47,
    parameter int OUT_N = 12,
    parameter int LANES = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IN_N*LANES-1:0]  lanes_i,
    input  logic [IN_N-1:0]        err_i,
    output logic [OUT_N*LANES-1:0] lanes_o,
    output logic [OUT_N-1:0]       err_o
);
    localparam int PAD_N = OUT_N * 4;
    localparam int PAD_W = PAD_N * LANES;

    typedef struct packed {
        logic [OUT_N*LANES-1:0] lanes;
        logic [OUT_N-1:0]       err;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    logic [PAD_W-1:0] lanes_pad;
    logic [PAD_N-1:0] err_pad;

    assign lanes_pad = PAD_W'(lanes_i);
    assign err_pad   = PAD_N'(err_i);

    always_comb begin
        logic [2:0] cnt;
        lvl_d = '0;
        for (int o = 0; o < OUT_N; o++) begin
            cnt = '0;
            for (int c = 0; c < 4; c++) begin
                for (int l = 0; l < LANES; l++) begin
                    lvl_d.lanes[o*LANES + l] = lvl_d.lanes[o*LANES + l]
                                             | lanes_pad[(4*o + c)*LANES + l];
                end
                lvl_d.err[o] = lvl_d.err[o] | err_pad[4*o + c];
                cnt = cnt + 3'(lanes_pad[(4*o + c)*LANES]);
            end
            if (cnt >= 3'd2) begin
                lvl_d.err[o] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lanes_o = lvl_q.lanes;
    assign err_o   = lvl_q.err;
endmodule

// File: rtl/onehot_rule_encoder.sv
module onehot_rule_encoder #(
    parameter int NUM_RULES = 47
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                valid_i,
    input  logic [NUM_RULES-1:0]                                match_i,
    output logic                                                out_valid_o,
    output logic                                                hit_o,
    output logic                                                err_o,
    output logic [((NUM_RULES > 1) ? $clog2(NUM_RULES) : 1)-1:0] idx_o
);
    localparam int IDX_W  = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1;
    localparam int LANES  = IDX_W + 1;
    localparam int LEVELS = enc_pkg::enc_levels(NUM_RULES);
    localparam int TOTAL  = enc_pkg::enc_base(NUM_RULES, LEVELS);
    localparam int FINAL  = enc_pkg::enc_base(NUM_RULES, LEVELS - 1);

    logic [NUM_RULES*LANES-1:0] lanes_d;
    logic [TOTAL*LANES-1:0]     tree_lanes;
    logic [TOTAL-1:0]           tree_err;

    // Gate with valid, then spread every rule over its lanes:
    // lane 0 = rule fired, lane 1+b = rule fired and bit b of its number set.
    always_comb begin
        lanes_d = '0;
        for (int r = 0; r < NUM_RULES; r++) begin
            lanes_d[r*LANES] = match_i[r] & valid_i;
            for (int b = 0; b < IDX_W; b++) begin
                lanes_d[r*LANES + 1 + b] = match_i[r] & valid_i & (((r >> b) & 1) != 0);
            end
        end
    end

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int IN_N  = enc_pkg::enc_nodes(NUM_RULES, k);
        localparam int OUT_N = enc_pkg::enc_nodes(NUM_RULES, k + 1);
        localparam int OB    = enc_pkg::enc_base(NUM_RULES, k);
        if (k == 0) begin : g_first
            enc_level #(.IN_N(IN_N), .OUT_N(OUT_N), .LANES(LANES)) u_level (
                .clk     (clk),
                .rst_n   (rst_n),
                .lanes_i (lanes_d),
                .err_i   ('0),
                .lanes_o (tree_lanes[OB*LANES +: OUT_N*LANES]),
                .err_o   (tree_err[OB +: OUT_N])
            );
        end else begin : g_next
            localparam int IB = enc_pkg::enc_base(NUM_RULES, k - 1);
            enc_level #(.IN_N(IN_N), .OUT_N(OUT_N), .LANES(LANES)) u_level (
                .clk     (clk),
                .rst_n   (rst_n),
                .lanes_i (tree_lanes[IB*LANES +: IN_N*LANES]),
                .err_i   (tree_err[IB +: IN_N]),
                .lanes_o (tree_lanes[OB*LANES +: OUT_N*LANES]),
                .err_o   (tree_err[OB +: OUT_N])
            );
        end
    end

    enc_valid_pipe #(.DEPTH(LEVELS)) u_vpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (valid_i),
        .q_o   (out_valid_o)
    );

    assign hit_o = tree_lanes[FINAL*LANES];
    assign idx_o = tree_lanes[FINAL*LANES + 1 +: IDX_W];
    assign err_o = tree_err[FINAL];
endmodule

// File: rtl/onehot_rule_encoder_chk.sv
module onehot_rule_encoder_chk #(
    parameter int NUM_RULES = 47,
    parameter int IDX_W     = 6,
    parameter int LEVELS    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 valid_i,
    input logic [NUM_RULES-1:0] match_i,
    input logic                 out_valid_o,
    input logic                 hit_o,
    input logic                 err_o,
    input logic [IDX_W-1:0]     idx_o
);
    logic [LEVELS-1:0] sh_vld, sh_le1, sh_none;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_vld  <= '0;
            sh_le1  <= '0;
            sh_none <= '0;
        end else begin
            sh_vld  <= LEVELS'({sh_vld,  valid_i});
            sh_le1  <= LEVELS'({sh_le1,  $onehot0(match_i)});
            sh_none <= LEVELS'({sh_none, (match_i == '0)});
        end
    end

    wire t_vld  = sh_vld[LEVELS-1];
    wire t_le1  = sh_le1[LEVELS-1];
    wire t_none = sh_none[LEVELS-1];

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o == t_vld);

    p_err_multi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_vld && !t_le1) |-> (err_o && hit_o));

    p_no_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_vld && t_le1) |-> !err_o);

    p_hit_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (t_vld && t_le1 && !t_none) |-> hit_o);

    p_zero_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (t_vld && t_none) |-> (!hit_o && idx_o == '0));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (!hit_o && !err_o && idx_o == '0));
endmodule

bind onehot_rule_encoder onehot_rule_encoder_chk #(
    .NUM_RULES (NUM_RULES),
    .IDX_W     (IDX_W),
    .LEVELS    (LEVELS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .match_i     (match_i),
    .out_valid_o (out_valid_o),
    .hit_o       (hit_o),
    .err_o       (err_o),
    .idx_o       (idx_o)
);

// File: tb/onehot_rule_encoder_test.sv
`timescale 1ns/1ps
module onehot_rule_encoder_test;
    localparam int R   = 47;
    localparam int IW  = 6;
    localparam int LAT = 3;

    typedef struct {
        logic          hit;
        logic          err;
        logic          chk_idx;
        logic [IW-1:0] idx;
        int            cyc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic [R-1:0]  match = '0;
    logic          out_valid, hit, err;
    logic [IW-1:0] idx;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];

    onehot_rule_encoder #(.NUM_RULES(R)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid),
        .match_i     (match),
        .out_valid_o (out_valid),
        .hit_o       (hit),
        .err_o       (err),
        .idx_o       (idx)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic drive(input logic v, input logic [R-1:0] m, input string tag);
        exp_t e;
        int   cnt;
        @(negedge clk);
        valid = v;
        match = m;
        if (v) begin
            cnt = $countones(m);
            e.hit     = (cnt != 0);
            e.err     = (cnt >= 2);
            e.chk_idx = (cnt < 2);
            e.idx     = '0;
            for (int i = 0; i < R; i++) if (m[i] && cnt == 1) e.idx = IW'(i);
            e.cyc = cyc;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    // Monitor: compare every result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc - e.cyc == LAT, {e.tag, " R5 R8 latency"}, cyc - e.cyc, LAT);
                    check(hit == e.hit, {e.tag, " hit"}, int'(hit), int'(e.hit));
                    check(err == e.err, {e.tag, " err"}, int'(err), int'(e.err));
                    if (e.chk_idx)
                        check(idx == e.idx, {e.tag, " idx"}, int'(idx), int'(e.idx));
                end
            end else begin
                check(!hit && !err && idx == '0, "R6 idle outputs", int'({hit, err, idx}), 0);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R7: outputs quiet during reset, even with activity on the inputs
        valid = 1'b1;
        match = '1;
        repeat (4) begin
            @(negedge clk);
            check(!out_valid && !hit && !err && idx == '0, "R7 reset outputs",
                  int'({out_valid, hit, err, idx}), 0);
        end
        valid = 1'b0;
        match = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R4 R8: every single rule, back to back
        for (int p = 0; p < R; p++) drive(1'b1, R'(1) << p, "R1 R4 one-hot");
        // R2: valid all-zero vector
        drive(1'b1, '0, "R2 zero");
        // R3: clashes within one group, across groups, and everything
        drive(1'b1, (R'(1) << 12) | (R'(1) << 13), "R3 same group");
        drive(1'b1, (R'(1) << 3) | (R'(1) << 4), "R3 cross group");
        drive(1'b1, (R'(1) << 0) | (R'(1) << 46), "R3 far ends");
        drive(1'b1, R'(7) << 5, "R3 three bits");
        drive(1'b1, '1, "R3 all ones");
        // R6: idle cycles carrying junk must leave no trace
        drive(1'b0, '1, "R6");
        drive(1'b1, R'(1) << 9, "R1 after idle");
        drive(1'b0, R'(1) << 9, "R6");
        drive(1'b0, '1, "R6");
        // R8: a clash directly followed by a clean vector and a zero vector
        drive(1'b1, '1, "R3 R8 clash");
        drive(1'b1, R'(1) << 33, "R1 R8 clean after clash");
        drive(1'b1, '0, "R2 R8 zero after rule");
        drive(1'b0, '0, "R6");

        repeat (LAT + 4) @(negedge clk);
        check(sb.size() == 0, "R5 drained", sb.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule